// File: doc/BRIEF.md
# Externally Clocked Serial Receiver with Overrun Lock

This block is the receive half of a synchronous serial slave port. The shift clock and the data line come from off-chip pins. Both pass through a flop synchroniser. On each rising edge of the synchronised serial clock, one data bit enters a shift register, most significant bit first. When a frame of `DATA_W` bits is complete, the frame moves into a receive buffer. At the same time a full flag is set and a one-cycle interrupt pulse is raised.

Software may fail to read the buffer before another frame completes. In that case the block enters a locked overrun state. The state keeps the unread frame in the buffer and the overrunning frame in the shift register. Serial clock edges stop shifting data while the lock holds.

Recovery follows a fixed order:
1. Clear the start bit.
2. Read the data register twice. The first read returns the older frame and the second returns the newer one.
3. Write 0 to the error bit. This also clears the full flag.

An inhibit write aborts reception at once and returns all state to its reset values.

Register port: a read returns its data on `reg_rdata` one clock after `reg_rd`.

| Address | Register | Bits |
|---|---|---|
| 0 | control | bit 0 = start (reads back); bit 1 = inhibit (write-only, reads 0) |
| 1 | status | bit 0 = full; bit 1 = error; bit 2 = busy |
| 2 | data | receive data |

Top module: `serial_rx_lock`

## Requirements
- R1: After reset the control and status registers and the data register read 0, and `irq` is 0.
- R2: With start set, `DATA_W` rising serial-clock edges receive one frame, first bit into the MSB. The frame then reads from address 2, and status bit 0 (full) is 1.
- R3: Each completed frame that sets the full flag from 0 produces exactly one `irq` pulse, one system clock wide.
- R4: With no error, every data read returns the buffer, and a data read clears the full flag.
- R5: A frame that completes while full is 1 sets status bit 1 (error) and produces no `irq`.
- R6: While the error flag is 1, serial-clock edges change neither the buffer nor the shift register.
- R7: While the error flag is 1, successive data reads alternate: first the buffered frame, then the overrunning frame, then the buffered frame again.
- R8: Writing status with bit 1 equal to 0 while in error clears both the error and full flags.
- R9: Writing start = 1 while the error flag is 1 leaves the start bit at 0.
- R10: After start is cleared, status bit 2 (busy) stays 1 until `DATA_W` further serial-clock edges have arrived, then drops to 0.
- R11: Writing 1 to control bit 1 (inhibit) returns start, busy, full, error and the buffer to 0 at once.
- R12: With busy 0, serial-clock edges receive nothing: status and data stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_pin | input | 1 | External serial clock, asynchronous |
| sdata_pin | input | 1 | External serial data, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid one clock after `reg_rd` |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The bench builds the block with `DATA_W` = 4 and `SYNC_STAGES` = 2. With 4-bit frames every frame value can be received in normal operation. The bench also drives every ordered pair of buffered and overrunning frames through the full lock-and-recover sequence: the frozen extra frame, the alternating reads, the refused restart, the busy drain count and the error clear. Expected values come from the frame arithmetic in the bench alone.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  localparam int CT_START = 0;
  localparam int CT_INH   = 1;
  localparam int ST_FULL  = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_BUSY  = 2;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) ff[i] <= 1'b0;
      else if (i == 0) ff[i] <= d;
      else ff[i] <= ff[(i == 0) ? 0 : i-1];
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         edge_i,
  input  logic         bit_i,
  input  logic         cnt_en,
  input  logic         shift_en,
  output logic [W-1:0] sh_o,
  output logic [W-1:0] sh_next_o,
  output logic         done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic [CW-1:0] cnt;

  assign sh_next_o = {sh_o[W-2:0], bit_i};
  assign done_o    = edge_i && cnt_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      sh_o <= '0;
    end else if (edge_i && cnt_en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (shift_en) sh_o <= sh_next_o;
    end
  end
endmodule

// File: rtl/serial_rx_lock.sv
module serial_rx_lock
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_pin,
  input  logic              sdata_pin,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic sclk_s, sdat_s, sclk_prev, sedge;
  logic start_q, busy_q, full_q, err_q, ptr_q, irq_q;
  logic [DATA_W-1:0] rbuf_q, sh_q, sh_next, stat_v, ctrl_v, rd_mux;
  logic frame_done, inhibit, unused_wbits;
  reg_addr_e addr;

  assign addr         = reg_addr_e'(reg_addr);
  assign unused_wbits = ^reg_wdata;
  assign inhibit      = reg_wr && (addr == A_CTRL) && reg_wdata[CT_INH];

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .d(sclk_pin), .q(sclk_s));
  srx_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst(rst), .d(sdata_pin), .q(sdat_s));

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end
  assign sedge = sclk_s & ~sclk_prev;

  srx_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .clr(inhibit),
    .edge_i(sedge), .bit_i(sdat_s),
    .cnt_en(busy_q), .shift_en(busy_q & ~err_q),
    .sh_o(sh_q), .sh_next_o(sh_next), .done_o(frame_done));

  always_ff @(posedge clk) begin
    if (rst || inhibit) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
      ptr_q   <= 1'b0;
      irq_q   <= 1'b0;
      rbuf_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      // data read: toggles the pointer in error, consumes the buffer otherwise
      if (reg_rd && addr == A_DATA) begin
        if (err_q) ptr_q <= ~ptr_q;
        else       full_q <= 1'b0;
      end
      // frame completion
      if (frame_done) begin
        if (!err_q) begin
          if (full_q) begin
            err_q <= 1'b1;
          end else begin
            rbuf_q <= sh_next;
            full_q <= 1'b1;
            irq_q  <= 1'b1;
          end
        end
        if (!start_q) busy_q <= 1'b0;
      end
      // control write
      if (reg_wr && addr == A_CTRL) begin
        if (!reg_wdata[CT_START]) begin
          start_q <= 1'b0;
        end else if (!err_q) begin
          start_q <= 1'b1;
          busy_q  <= 1'b1;
        end
      end
      // status write: a 0 in the error bit releases the lock
      if (reg_wr && addr == A_STAT && err_q && !reg_wdata[ST_ERR]) begin
        err_q  <= 1'b0;
        full_q <= 1'b0;
        ptr_q  <= 1'b0;
      end
    end
  end

  assign irq = irq_q;

  always_comb begin
    stat_v          = '0;
    stat_v[ST_FULL] = full_q;
    stat_v[ST_ERR]  = err_q;
    stat_v[ST_BUSY] = busy_q;
    ctrl_v           = '0;
    ctrl_v[CT_START] = start_q;
    case (addr)
      A_CTRL:  rd_mux = ctrl_v;
      A_STAT:  rd_mux = stat_v;
      A_DATA:  rd_mux = (err_q && ptr_q) ? sh_q : rbuf_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         irq,
  input logic         full_q,
  input logic         err_q,
  input logic         start_q,
  input logic [W-1:0] sh_q,
  input logic [W-1:0] rbuf_q
);
  p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_on_full_rise_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (full_q && !$past(full_q)));

  p_no_irq_in_err_r5: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !irq);

  p_err_keeps_full_r5: assert property (@(posedge clk) disable iff (rst)
    err_q |-> full_q);

  p_frozen_in_err_r6: assert property (@(posedge clk) disable iff (rst)
    (err_q && $past(err_q)) |-> ($stable(sh_q) && $stable(rbuf_q)));

  p_no_restart_in_err_r9: assert property (@(posedge clk) disable iff (rst)
    (err_q && $past(err_q)) |-> !$rose(start_q));
endmodule

bind serial_rx_lock srx_checker #(.W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .full_q(full_q), .err_q(err_q),
  .start_q(start_q), .sh_q(sh_q), .rbuf_q(rbuf_q));

// File: tb/sim_serial_rx_lock.sv
module sim_serial_rx_lock;
  localparam int W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk_pin = 1'b0, sdata_pin = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic irq;

  int n_tests = 0, n_fail = 0, irq_hi = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_rx_lock #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .sclk_pin(sclk_pin), .sdata_pin(sdata_pin),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always @(posedge clk) if (!rst && irq) irq_hi++;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    sdata_pin = b;
    repeat (3) @(negedge clk);
    sclk_pin = 1'b1;
    repeat (4) @(negedge clk);
    sclk_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int v);
    for (int i = W-1; i >= 0; i--) send_bit(v[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 status", v, 0);
    rd(2, v); chk("R1 data", v, 0);

    // R12 idle edges ignored
    send_frame(4'hA);
    rd(1, v); chk("R12 status", v, 0);
    rd(2, v); chk("R12 data", v, 0);

    // R2 R3 R4 every frame value
    wr(0, 1);
    for (int f = 0; f < (1 << W); f++) begin
      h0 = irq_hi;
      send_frame(f);
      chk("R3 irq pulse", irq_hi - h0, 1);
      rd(1, v); chk("R2 status full", v, 5);
      rd(2, v); chk("R2 data", v, f);
      rd(2, v); chk("R4 reread", v, f);
      rd(1, v); chk("R4 full cleared", v, 4);
    end

    // R5..R10 overrun lock and recovery, all pairs
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        wr(0, 1);
        h0 = irq_hi;
        send_frame(a);
        send_frame(b);
        chk("R5 one irq", irq_hi - h0, 1);
        rd(1, v); chk("R5 status err", v, 7);
        send_frame(~b & ((1 << W) - 1));
        wr(0, 0);
        rd(2, v); chk("R7 first read", v, a);
        rd(2, v); chk("R6 R7 second read", v, b);
        rd(2, v); chk("R7 third read", v, a);
        wr(0, 1);
        rd(0, v); chk("R9 start refused", v, 0);
        for (int i = 0; i < W-1; i++) send_bit(1'b0);
        rd(1, v); chk("R10 busy held", v, 7);
        send_bit(1'b0);
        rd(1, v); chk("R10 busy dropped", v, 3);
        wr(1, 0);
        rd(1, v); chk("R8 cleared", v, 0);
      end
    end

    // R11 inhibit
    wr(0, 1);
    send_frame(4'h5);
    send_frame(4'h9);
    rd(1, v); chk("R11 pre err", v, 7);
    wr(0, 2);
    rd(1, v); chk("R11 status", v, 0);
    rd(0, v); chk("R11 ctrl", v, 0);
    rd(2, v); chk("R11 data", v, 0);
    send_frame(4'h6);
    rd(1, v); chk("R11 R12 idle after", v, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule